// File: doc/BRIEF.md
# Strobe delay margin control

This block owns the tap code that sets a delay line on an incoming data strobe. The nominal setting, a quarter of the strobe period, arrives as a code from a delay-locked loop. The block has two modes, chosen by one input. In tracking mode the applied code is a registered copy of the loop code.

In margin mode the applied code stops following the loop directly. Software or calibration logic can then nudge it one tap at a time, using a move strobe and a direction bit. An internal change tracker keeps a private copy of the last loop code it has followed. Whenever the live loop code differs from that copy, the tracker issues single-tap steps toward it, spaced by a minimum gap. Loop drift is therefore still followed, and the manual offset is preserved on top of it.

A pause input freezes the applied code in both modes. Loop changes seen during a pause are not lost: the tracker still holds the difference and works it off once pause is released. A manual move whose rising edge falls inside a pause is dropped.

Top module: `strobe_tap_ctrl`

## Requirements
- R1: Synchronous active-high reset sets the applied code to 0 and clears any pending tracker step.
- R2: With margin_en low and pause low, tap_code equals the loop_code sampled at the previous clock edge.
- R3: With margin_en high, tap_code converges to the tap code held when margin mode was entered, plus the loop code change since then, plus the net manual offset. It reaches that value within 4 cycles per tap of loop change, plus a small fixed latency.
- R4: In margin mode with pause low, a rising edge on move changes tap_code by exactly one tap, one clock after the edge. The step is up when move_up is 1 and down when move_up is 0, however long move stays high.
- R5: A step up at 127 leaves the code at 127, and a step down at 0 leaves it at 0; the code never wraps.
- R6: Tracker steps are applied at most once every 4 clock cycles, upward when the loop code rose and downward when it fell.
- R7: While pause is high, tap_code does not change. Loop changes that arrive during the pause take effect after it ends, in either mode.
- R8: A move rising edge that occurs while pause is high has no effect on tap_code, neither during the pause nor after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_code | input | 7 | Delay code from the delay-locked loop |
| margin_en | input | 1 | 0: tracking mode, 1: margin mode (freeze and step) |
| move | input | 1 | Manual step strobe, acted on at its rising edge |
| move_up | input | 1 | Manual step direction, 1 up, 0 down |
| pause | input | 1 | Holds the applied code while high |
| tap_code | output | 7 | Registered tap code applied to the strobe delay line |

## Verification
Four properties are checked on every cycle. A high pause leaves the code stable on the next cycle. Tracking mode copies the loop code one cycle later. In margin mode the code never moves by more than two taps per cycle, so it cannot wrap. Consumed tracker steps are never closer together than the minimum gap. The bench scenarios are needed for the rest: convergence to the loop code plus the manual offset over a random walk, one tap per move edge regardless of pulse width, saturation at both ends, and moves dropped during a pause while deferred loop changes are applied after it.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int CODE_W_DEF = 7;
  localparam int GAP_DEF    = 4;
endpackage

// File: rtl/stc_edge.sv
module stc_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b1;
    else     sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/stc_tracker.sv
module stc_tracker #(
  parameter int CODE_W = stc_pkg::CODE_W_DEF,
  parameter int GAP    = stc_pkg::GAP_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              margin,
  input  logic              pause,
  input  logic [CODE_W-1:0] loop_code,
  output logic              step,
  output logic              step_up
);
  localparam int GW = $clog2(GAP + 1);
  localparam logic [GW-1:0] RELOAD = GW'(GAP - 2);

  logic [CODE_W-1:0] ref_code;
  logic [GW-1:0]     gap_cnt;
  logic              pend;
  logic              pend_up;
  logic              consume;

  assign consume = pend & ~pause;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_code <= '0;
      gap_cnt  <= '0;
      pend     <= 1'b0;
      pend_up  <= 1'b0;
    end else if (!margin) begin
      pend    <= 1'b0;
      gap_cnt <= '0;
      if (!pause) ref_code <= loop_code;
    end else begin
      if (consume) begin
        pend    <= 1'b0;
        gap_cnt <= RELOAD;
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
      if (!pend && !pause && gap_cnt == '0 && loop_code != ref_code) begin
        pend    <= 1'b1;
        pend_up <= (loop_code > ref_code);
        if (loop_code > ref_code) ref_code <= ref_code + 1'b1;
        else                      ref_code <= ref_code - 1'b1;
      end
    end
  end

  assign step    = consume;
  assign step_up = pend_up;

  int since_step;
  always_ff @(posedge clk) begin
    if (rst)                 since_step <= GAP;
    else if (step)           since_step <= 0;
    else if (since_step < GAP) since_step <= since_step + 1;
  end

  AST_TRK_SPACING: assert property (@(posedge clk) disable iff (rst)
    step |-> (since_step >= GAP - 1)); // R6
endmodule

// File: rtl/stc_stepper.sv
module stc_stepper #(
  parameter int CODE_W = stc_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              margin,
  input  logic              pause,
  input  logic [CODE_W-1:0] loop_code,
  input  logic              man_step,
  input  logic              man_up,
  input  logic              trk_step,
  input  logic              trk_up,
  output logic [CODE_W-1:0] tap
);
  localparam int MAXV = (1 << CODE_W) - 1;
  localparam int SW   = CODE_W + 3;

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] d_man;
  logic signed [SW-1:0] d_trk;
  logic [CODE_W-1:0]    sat_val;

  always_comb begin
    d_man = '0;
    d_trk = '0;
    if (man_step) d_man = man_up ? SW'(1) : -SW'(1);
    if (trk_step) d_trk = trk_up ? SW'(1) : -SW'(1);
    sum = $signed({3'b000, tap}) + d_man + d_trk;
    if (sum < 0)               sat_val = '0;
    else if (sum > SW'(MAXV))  sat_val = CODE_W'(MAXV);
    else                       sat_val = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          tap <= '0;
    else if (pause)   tap <= tap;
    else if (!margin) tap <= loop_code;
    else              tap <= sat_val;
  end

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    pause |=> $stable(tap)); // R7

  AST_TRACK_COPY: assert property (@(posedge clk) disable iff (rst)
    (!margin && !pause) |=> (tap == $past(loop_code))); // R2

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    margin |=> ((int'(tap) - int'($past(tap)) <= 2) &&
                (int'($past(tap)) - int'(tap) <= 2))); // R5
endmodule

// File: rtl/strobe_tap_ctrl.sv
module strobe_tap_ctrl #(
  parameter int CODE_W = stc_pkg::CODE_W_DEF,
  parameter int GAP    = stc_pkg::GAP_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] loop_code,
  input  logic              margin_en,
  input  logic              move,
  input  logic              move_up,
  input  logic              pause,
  output logic [CODE_W-1:0] tap_code
);
  logic move_rise;
  logic man_step;
  logic trk_step;
  logic trk_up;

  stc_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig  (move),
    .rise (move_rise)
  );

  assign man_step = move_rise & margin_en & ~pause;

  stc_tracker #(.CODE_W(CODE_W), .GAP(GAP)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .margin    (margin_en),
    .pause     (pause),
    .loop_code (loop_code),
    .step      (trk_step),
    .step_up   (trk_up)
  );

  stc_stepper #(.CODE_W(CODE_W)) u_step (
    .clk       (clk),
    .rst       (rst),
    .margin    (margin_en),
    .pause     (pause),
    .loop_code (loop_code),
    .man_step  (man_step),
    .man_up    (move_up),
    .trk_step  (trk_step),
    .trk_up    (trk_up),
    .tap       (tap_code)
  );
endmodule

// File: tb/sim_strobe_tap_ctrl.sv
`timescale 1ns/1ps
module sim_strobe_tap_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] loop_code = '0;
  logic       margin_en = 1'b0;
  logic       move = 1'b0;
  logic       move_up = 1'b0;
  logic       pause = 1'b0;
  logic [6:0] tap_code;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  strobe_tap_ctrl u0 (
    .clk(clk), .rst(rst), .loop_code(loop_code), .margin_en(margin_en),
    .move(move), .move_up(move_up), .pause(pause), .tap_code(tap_code)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: tap actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_move(input logic up, input int width);
    move_up = up;
    move = 1'b1;
    cyc(width);
    move = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    check("R1", tap_code, 0);
  endtask

  task automatic t_tracking;
    margin_en = 1'b0;
    loop_code = 7'd40; cyc(1); check("R2", tap_code, 40);
    loop_code = 7'd17; cyc(1); check("R2", tap_code, 17);
    loop_code = 7'd40; cyc(1); check("R2", tap_code, 40);
  endtask

  task automatic t_pause_tracking;
    pause = 1'b1;
    loop_code = 7'd50;
    cyc(3); check("R7", tap_code, 40);
    pause = 1'b0;
    cyc(1); check("R7", tap_code, 50);
  endtask

  task automatic t_manual;
    margin_en = 1'b1;
    cyc(2); check("R3", tap_code, 50);
    pulse_move(1'b1, 5); check("R4", tap_code, 51);
    pulse_move(1'b0, 1); pulse_move(1'b0, 3); check("R4", tap_code, 49);
  endtask

  task automatic t_track_rate;
    int base;
    base = tap_code;
    loop_code = 7'd55;
    cyc(6);
    n_chk++;
    if (int'(tap_code) - base > 2 || int'(tap_code) - base < 1) begin
      n_bad++;
      $display("FAIL R6: tap actual %0d expected %0d..%0d", tap_code, base + 1, base + 2);
    end
    cyc(30); check("R3", tap_code, 54);
    loop_code = 7'd52;
    cyc(20); check("R6", tap_code, 51);
  endtask

  task automatic t_pause_margin;
    pause = 1'b1;
    loop_code = 7'd56;
    cyc(2);
    pulse_move(1'b1, 2);
    cyc(20); check("R7", tap_code, 51);
    pause = 1'b0;
    cyc(30); check("R8", tap_code, 55);
  endtask

  task automatic t_random_walk;
    int lc, expv, d;
    lc = 56; expv = 55;
    for (int k = 0; k < 40; k++) begin
      d = int'($urandom_range(0, 6)) - 3;
      if (lc + d < 20 || lc + d > 100) d = -d;
      lc = lc + d;
      expv = expv + d;
      loop_code = 7'(lc);
      if (k % 5 == 2) begin
        pulse_move(k % 2 == 0, 1);
        expv = expv + ((k % 2 == 0) ? 1 : -1);
      end
      cyc(4 * 3 + 8);
      check("R3", tap_code, expv);
    end
  endtask

  task automatic t_saturate;
    margin_en = 1'b0; loop_code = 7'd126; cyc(2);
    margin_en = 1'b1; cyc(1);
    pulse_move(1'b1, 1); pulse_move(1'b1, 1); pulse_move(1'b1, 1);
    check("R5", tap_code, 127);
    margin_en = 1'b0; loop_code = 7'd1; cyc(2);
    margin_en = 1'b1; cyc(1);
    pulse_move(1'b0, 1); pulse_move(1'b0, 1); pulse_move(1'b0, 2);
    check("R5", tap_code, 0);
  endtask

  initial begin
    cyc(1);
    t_reset;
    t_tracking;
    t_pause_tracking;
    t_manual;
    t_track_rate;
    t_pause_margin;
    t_random_walk;
    t_saturate;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule